// File: doc/BRIEF.md
# Parameterized Command Repeat Sequencer

This block takes one stored bus-transaction command (start address and burst length) and replays it toward a downstream master engine under the control of a 32-bit parameter word. Software fills a parameter memory through a write port. Each memory entry belongs to the command slot with the same index. When `start` is pulsed with a slot index, the sequencer reads that slot's word and decodes it. It then produces one or more issue requests on a valid/ready port. Each request carries a computed address, and an optional idle wait can come before it.

The state machine has five named states. S_IDLE waits for `start` and reads the parameter memory (transition IDLE→LOAD). S_LOAD decodes the word and goes to S_WAIT when a pre-delay is programmed, or to S_ISSUE when it is not. S_WAIT counts idle cycles and moves to S_ISSUE when the count runs out. S_ISSUE holds the request until it is accepted. After an accepted request that is not the last one, S_ISSUE goes to S_WAIT when an interval is programmed and stays in S_ISSUE when none is. The last accepted request sends the machine to S_DONE. S_DONE raises `done` for one cycle and returns to S_IDLE.

Opcodes (word bits [31:29]) are 000 pass, 001 repeat, 010 pre-delay and 011 fixed-repeat-with-interval. Any other value acts as pass. Address modes (bits [25:24]) are 00 hold, 01 step and 10 random. A random offset comes from a free-running 32-bit LFSR and is masked into a power-of-two span above a base address. Reads aimed at the parameter window are not served by this block; they belong to the register space.

Top module: `rptseq_top`

## Requirements
- R1: After reset, `busy`, `iss_valid` and `done` are 0.
- R2: A write with byte address in [0x1000, 0x1000 + 4·SLOTS) stores `cfg_wr_data` into slot (address − 0x1000)/4. A write to an address outside that range changes no slot.
- R3: Opcodes 000 and 100–111 produce exactly one request at `cmd_addr`. It is visible two cycles after `start` is sampled.
- R4: Opcode 001 produces N back-to-back requests, where N is bits [7:0]. A value of 0 counts as 1.
- R5: Opcode 010 produces one request that appears D cycles later than a pass request would, where D is bits [19:0].
- R6: Opcode 011 produces FIXED_REPEATS requests. After each accepted request that is not the last, G idle cycles pass before the next request, where G is bits [19:8].
- R7: Address mode 00 or 11 gives every request the address `cmd_addr`.
- R8: Address mode 01 adds BUS_BYTES·(`cmd_len`+1) to the address after each accepted request.
- R9: Address mode 10 with opcode 011 gives addresses in [RAND_BASE, RAND_BASE+RAND_SPAN) whose low log2(BUS_BYTES) bits are zero. With any other opcode, address mode 10 acts as mode 00.
- R10: Bit 28 of the parameter word has no effect.
- R11: While `iss_valid` is high and `iss_ready` is low, the request and its address stay unchanged. Only accepted requests count toward the total.
- R12: `done` is high for exactly one cycle, in the cycle after the last request is accepted. `busy` is high from the cycle after `start` through `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Parameter write strobe |
| cfg_wr_addr | input | 16 | Parameter write byte address |
| cfg_wr_data | input | 32 | Parameter word |
| start | input | 1 | Begin a sequence (sampled when idle) |
| slot_idx | input | IDX_W | Command slot to run |
| cmd_addr | input | ADDR_W | Command start address |
| cmd_len | input | LEN_W | Command burst length field |
| busy | output | 1 | Sequence in progress |
| iss_valid | output | 1 | Request valid |
| iss_ready | input | 1 | Downstream accepts request |
| iss_addr | output | ADDR_W | Request address |
| iss_len | output | LEN_W | Request burst length |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach is a request held by back-pressure in the middle of a stepping sequence. In that case the address must not advance and the remaining count must not drop. The stimulus runs a four-repeat incrementing command while `iss_ready` toggles every cycle. The monitor checks that each stalled request keeps its address into the next cycle and that the addresses still come out in the expected order. Random addressing cannot be predicted from the ports, so those requests are checked for range and alignment only.

// File: rtl/rptseq_pkg.sv
package rptseq_pkg;
    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_ISSUE, S_DONE} seq_state_t;
    typedef enum logic [1:0] {AM_HOLD, AM_STEP, AM_RAND} amode_t;

    localparam logic [2:0] OPC_PASS   = 3'b000;
    localparam logic [2:0] OPC_REPEAT = 3'b001;
    localparam logic [2:0] OPC_DELAY  = 3'b010;
    localparam logic [2:0] OPC_FIXED  = 3'b011;

    typedef struct packed {
        logic [7:0]  count;
        logic [19:0] pre_wait;
        logic [11:0] gap;
        amode_t      amode;
    } plan_t;
endpackage

// File: rtl/rptseq_store.sv
module rptseq_store #(
    parameter int SLOTS    = 256,
    parameter int WIN_BASE = 32'h1000,
    localparam int IDX_W   = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word
);
    localparam logic [31:0] WIN_LO = 32'(WIN_BASE);
    localparam logic [31:0] WIN_HI = 32'(WIN_BASE + SLOTS * 4);

    logic [31:0]      mem [SLOTS];
    logic [31:0]      wa32;
    logic [31:0]      woff;
    logic             in_win;
    logic [IDX_W-1:0] widx;

    assign wa32   = 32'(wr_addr);
    assign woff   = wa32 - WIN_LO;
    assign in_win = (wa32 >= WIN_LO) && (wa32 < WIN_HI);
    assign widx   = IDX_W'(woff >> 2);

    always_ff @(posedge clk) begin
        if (wr_en && in_win) mem[widx] <= wr_data;
        if (rd_en)           rd_word   <= mem[rd_idx];
    end
endmodule

// File: rtl/rptseq_decode.sv
module rptseq_decode
    import rptseq_pkg::*;
#(
    parameter int FIXED_REPEATS = 3
) (
    input  logic [31:0] word,
    output plan_t       plan
);
    logic [2:0] op;
    logic [1:0] am_raw;

    assign op     = word[31:29];
    assign am_raw = word[25:24];

    always_comb begin
        plan          = '0;
        plan.count    = 8'd1;
        plan.amode    = AM_HOLD;
        case (op)
            OPC_REPEAT: plan.count    = (word[7:0] == 8'd0) ? 8'd1 : word[7:0];
            OPC_DELAY:  plan.pre_wait = word[19:0];
            OPC_FIXED: begin
                plan.count = 8'(FIXED_REPEATS);
                plan.gap   = word[19:8];
            end
            default: ;
        endcase
        if (am_raw == 2'b01)                          plan.amode = AM_STEP;
        else if (am_raw == 2'b10 && op == OPC_FIXED)  plan.amode = AM_RAND;
    end
endmodule

// File: rtl/rptseq_addr.sv
module rptseq_addr
    import rptseq_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          LEN_W     = 8,
    parameter int          BUS_BYTES = 4,
    parameter logic [31:0] RAND_BASE = 32'h0000_4000,
    parameter int          RAND_SPAN = 4096,
    parameter logic [31:0] LFSR_SEED = 32'hACE1_1234
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  amode_t            amode,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int          SPAN_W = $clog2(RAND_SPAN);
    localparam logic [31:0] TAPS   = 32'h8020_0003;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BUS_BYTES - 1);

    logic [31:0]       lfsr_q;
    amode_t            amode_q;
    logic [ADDR_W-1:0] rand_addr;
    logic [ADDR_W-1:0] step;

    assign rand_addr = (ADDR_W'(RAND_BASE) + ADDR_W'(lfsr_q[SPAN_W-1:0])) & ALIGN_MASK;
    assign step      = ADDR_W'(BUS_BYTES) * (ADDR_W'(len) + ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q   <= LFSR_SEED;
            amode_q  <= AM_HOLD;
            cur_addr <= '0;
        end else begin
            lfsr_q <= {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? TAPS : 32'h0);
            if (load) begin
                amode_q  <= amode;
                cur_addr <= (amode == AM_RAND) ? rand_addr : start_addr;
            end else if (advance) begin
                unique case (amode_q)
                    AM_STEP: cur_addr <= cur_addr + step;
                    AM_RAND: cur_addr <= rand_addr;
                    default: cur_addr <= cur_addr;
                endcase
            end
        end
    end

    p_rand_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((load && amode == AM_RAND) || (!load && advance && amode_q == AM_RAND)) |=>
            (cur_addr >= ADDR_W'(RAND_BASE)) &&
            (cur_addr < ADDR_W'(RAND_BASE) + ADDR_W'(RAND_SPAN)) &&
            ((cur_addr & ADDR_W'(BUS_BYTES - 1)) == '0));
endmodule

// File: rtl/rptseq_top.sv
module rptseq_top
    import rptseq_pkg::*;
#(
    parameter int          ADDR_W        = 32,
    parameter int          LEN_W         = 8,
    parameter int          BUS_BYTES     = 4,
    parameter int          SLOTS         = 256,
    parameter int          FIXED_REPEATS = 3,
    parameter logic [31:0] RAND_BASE     = 32'h0000_4000,
    parameter int          RAND_SPAN     = 4096,
    localparam int         IDX_W         = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [15:0]       cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              start,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              busy,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [LEN_W-1:0]  iss_len,
    output logic              done
);
    seq_state_t        state_q, state_d;
    logic [31:0]       word;
    plan_t             plan;
    logic [7:0]        rem_q;
    logic [19:0]       wait_q;
    logic [11:0]       gap_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              launch, accept, last;

    assign launch = (state_q == S_IDLE) && start;
    assign accept = (state_q == S_ISSUE) && iss_ready;
    assign last   = (rem_q == 8'd1);

    rptseq_store #(.SLOTS(SLOTS), .WIN_BASE(32'h1000)) store_i (
        .clk(clk), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .rd_en(launch), .rd_idx(slot_idx), .rd_word(word)
    );

    rptseq_decode #(.FIXED_REPEATS(FIXED_REPEATS)) decode_i (.word(word), .plan(plan));

    rptseq_addr #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES),
        .RAND_BASE(RAND_BASE), .RAND_SPAN(RAND_SPAN), .LFSR_SEED(32'hACE1_1234)
    ) addr_i (
        .clk(clk), .rst_n(rst_n), .load(state_q == S_LOAD), .advance(accept && !last),
        .amode(plan.amode), .start_addr(addr_q), .len(len_q), .cur_addr(iss_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LOAD;
            S_LOAD:  state_d = (plan.pre_wait != '0) ? S_WAIT : S_ISSUE;
            S_WAIT:  if (wait_q == 20'd1) state_d = S_ISSUE;
            S_ISSUE: if (iss_ready) state_d = last ? S_DONE :
                                              (gap_q != '0) ? S_WAIT : S_ISSUE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rem_q   <= '0;
            wait_q  <= '0;
            gap_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                addr_q <= cmd_addr;
                len_q  <= cmd_len;
            end
            if (state_q == S_LOAD) begin
                rem_q  <= plan.count;
                gap_q  <= plan.gap;
                wait_q <= plan.pre_wait;
            end else if (state_q == S_WAIT) begin
                wait_q <= wait_q - 20'd1;
            end else if (accept && !last) begin
                rem_q  <= rem_q - 8'd1;
                wait_q <= 20'(gap_q);
            end
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        iss_valid = (state_q == S_ISSUE);
        done      = (state_q == S_DONE);
        iss_len   = len_q;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr)));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_last_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && last) |=> done);
    p_more_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && !last) |=> (busy && !done));
    p_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

// File: tb/rptseq_top_tb_top.sv
module rptseq_top_tb_top;
    localparam logic [31:0] RB   = 32'h0000_4000;
    localparam int          RS   = 4096;

    typedef struct {
        logic [31:0] addr;
        int          gap;
        bit          rnd;
        bit          last;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wr_en = 0;
    logic [15:0] cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        start = 0;
    logic [7:0]  slot_idx = '0;
    logic [31:0] cmd_addr = '0;
    logic [7:0]  cmd_len = '0;
    logic        busy, iss_valid, iss_ready, done;
    logic [31:0] iss_addr;
    logic [7:0]  iss_len;

    int n_chk = 0, n_fail = 0, cyc = 0, last_evt = 0, done_cnt = 0;
    bit chk_done = 0, hold_pend = 0, stall = 0;
    logic [31:0] hold_addr;
    logic [7:0]  exp_len;
    item_t q[$];

    always #10 clk = ~clk;

    rptseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
        .cfg_wr_data(cfg_wr_data), .start(start), .slot_idx(slot_idx), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .busy(busy), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_addr(iss_addr), .iss_len(iss_len), .done(done)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic push(logic [31:0] a, int g, bit r, bit l);
        item_t it;
        it.addr = a; it.gap = g; it.rnd = r; it.last = l;
        q.push_back(it);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(posedge clk); #2;
        cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d;
        @(posedge clk); #2;
        cfg_wr_en = 0;
    endtask

    task automatic run(logic [7:0] s, logic [31:0] a, logic [7:0] l);
        int n0;
        n0 = done_cnt;
        exp_len = l;
        @(posedge clk); #2;
        start = 1; slot_idx = s; cmd_addr = a; cmd_len = l;
        @(posedge clk); #2;
        start = 0;
        wait (done_cnt == n0 + 1);
        @(negedge clk);
        chk(!busy, "R12", "busy after done", busy, 0);
        chk(q.size() == 0, "R4", "requests left", q.size(), 0);
        q.delete();
    endtask

    // ready driver
    always @(posedge clk) begin
        #2;
        iss_ready <= stall ? ~iss_ready : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (start) last_evt = cyc;
            if (chk_done) begin
                chk(done == 1'b1, "R12", "done pulse", done, 1);
                chk_done = 0;
                done_cnt++;
            end else if (done) begin
                chk(0, "R12", "unexpected done", done, 0);
                done_cnt++;
            end
            if (hold_pend) begin
                chk(iss_valid == 1'b1, "R11", "valid held", iss_valid, 1);
                chk(iss_addr == hold_addr, "R11", "address held", iss_addr, hold_addr);
            end
            hold_pend = iss_valid && !iss_ready;
            hold_addr = iss_addr;
            if (iss_valid && iss_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R4", "extra request", iss_addr, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.rnd) begin
                        chk(iss_addr >= RB && iss_addr < RB + RS && iss_addr[1:0] == 2'b00,
                            "R9", "random address window", iss_addr, RB);
                    end else begin
                        chk(iss_addr == it.addr, "R7/R8", "address", iss_addr, it.addr);
                    end
                    chk(iss_len == exp_len, "R3", "length", iss_len, exp_len);
                    chk(busy == 1'b1, "R12", "busy while issuing", busy, 1);
                    if (it.gap >= 0)
                        chk(cyc - last_evt == it.gap, "R5/R6", "spacing", cyc - last_evt, it.gap);
                    last_evt = cyc;
                    if (it.last) chk_done = 1;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        iss_ready = 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk(!busy && !iss_valid && !done, "R1", "reset outputs", {busy, iss_valid, done}, 0);

        wr(16'h1000, 32'h0000_0000);  // slot0 pass
        wr(16'h1004, 32'h2100_0004);  // slot1 repeat 4, step
        wr(16'h1008, 32'h4000_0005);  // slot2 delay 5
        wr(16'h100C, 32'h6000_0300);  // slot3 fixed, gap 3, hold
        wr(16'h1010, 32'h6200_0200);  // slot4 fixed, gap 2, random
        wr(16'h1014, 32'h2200_0002);  // slot5 repeat 2, random -> hold
        wr(16'h1018, 32'h3000_0003);  // slot6 repeat 3 with bit 28 set
        wr(16'h101C, 32'h2000_0000);  // slot7 repeat 0
        wr(16'h1020, 32'hE000_0005);  // slot8 opcode 111
        wr(16'h1024, 32'h2300_0002);  // slot9 repeat 2, mode 11
        wr(16'h1400, 32'h2000_0005);  // outside window
        wr(16'h0FFC, 32'h2000_0005);  // outside window

        // R3 and R2: slot0 stays pass despite out-of-window writes
        push(32'h100, 2, 0, 1);
        run(0, 32'h100, 3);
        // R4, R8
        for (int k = 0; k < 4; k++) push(32'h200 + 16 * k, (k == 0) ? 2 : 1, 0, k == 3);
        run(1, 32'h200, 3);
        // R5
        push(32'h180, 7, 0, 1);
        run(2, 32'h180, 0);
        // R6, R7
        for (int k = 0; k < 3; k++) push(32'h500, (k == 0) ? 2 : 4, 0, k == 2);
        run(3, 32'h500, 1);
        // R9 random
        for (int k = 0; k < 3; k++) push(32'h0, (k == 0) ? 2 : 3, 1, k == 2);
        run(4, 32'h600, 1);
        // R9 random ignored without fixed opcode
        for (int k = 0; k < 2; k++) push(32'h700, (k == 0) ? 2 : 1, 0, k == 1);
        run(5, 32'h700, 2);
        // R10
        for (int k = 0; k < 3; k++) push(32'h800, (k == 0) ? 2 : 1, 0, k == 2);
        run(6, 32'h800, 2);
        // R4 zero count
        push(32'h900, 2, 0, 1);
        run(7, 32'h900, 0);
        // R3 spare opcode
        push(32'hA00, 2, 0, 1);
        run(8, 32'hA00, 0);
        // R7 mode 11
        for (int k = 0; k < 2; k++) push(32'hB00, (k == 0) ? 2 : 1, 0, k == 1);
        run(9, 32'hB00, 0);
        // R11 back-pressure on stepping sequence
        stall = 1;
        for (int k = 0; k < 4; k++) push(32'hC00 + 8 * k, -1, 0, k == 3);
        run(1, 32'hC00, 1);
        stall = 0;
        repeat (3) @(posedge clk);
        report();
    end
endmodule